// File: doc/BRIEF.md
# Byte-Command I2C Bus Master

This block is a master for a two-wire I2C bus. Software runs it through five 32-bit registers, selected by a word index. Each command from software runs exactly one byte-level step on the bus. Software first loads the outgoing byte and then writes a control word. The control word asks for any mix of these, in this order: a START (or repeated START), one byte written or read, and a STOP. For a read, the control word also carries the acknowledge level the master should send. When the step ends, a done flag goes high. Software clears it by writing a one back to the same bit.

Both bus lines are open-drain. An output high pulls the line low, and an output low releases it. Each bit takes five prescaler ticks. A tick lasts (prescaler+1) clock cycles, so the SCL frequency is f_clk / (5 × (prescaler+1)). To pick 100 kHz, 400 kHz or 1 MHz, software loads prescaler = f_clk/(5·f_SCL) − 1. The block watches the bus lines, which are synchronised into the clock domain. It reports the bus as busy from any START until the next STOP. If it releases SDA during its own data bit but the line reads low, it stops at once and flags lost arbitration.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, every register reads zero and both line outputs are released.
- R2: Register index 0 is the configuration word: enable in bit 0, soft reset in bit 1, prescaler in bits 31:16. A write updates the prescaler only if enable was 0 before that write. The enable and soft-reset bits are always written.
- R3: While a byte runs, SCL rises every 5×(P+1) clocks and stays high for 2×(P+1) clocks, where P is the prescaler.
- R4: A command with START (bit 7) and WRITE (bit 4) of index 1 produces a START condition, then the byte from index 2, most significant bit first. The slave's acknowledge level is stored in status bit 2 of index 4, where 0 means acknowledged.
- R5: A READ command (bit 5) shifts in 8 bits, most significant bit first, into bits 7:0 of index 3. It then drives the ACK-in bit (bit 3) as the acknowledge: 1 means NACK (line released) and 0 means ACK (line low).
- R6: A command with STOP (bit 6) ends with a STOP condition after the byte and its acknowledge. Both lines are left released.
- R7: Done (bit 0 of index 1) sets when a command finishes. While a command runs, its command bits read back in index 1, and they read zero once it finishes. Writing index 1 with bit 0 set clears done.
- R8: Status bit 1 (busy) sets when a START condition is seen on the bus and clears when a STOP condition is seen.
- R9: If SDA reads low while the master is releasing it for a 1 data bit, the command aborts. Status bit 0 (arbitration lost) and done both set, and both lines are released. The next accepted command clears the arbitration-lost bit.
- R10: While enable is 0 or soft reset is 1, the engine is held idle with both lines released, and control-word commands are ignored. Setting soft reset during a command aborts that command without setting done.
- R11: SDA changes while SCL is high only to form a START or STOP condition. Each transaction shows exactly one START and one STOP on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_idx | input | 3 | Register word index (0 config, 1 control, 2 transmit, 3 receive, 4 status) |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_idx (combinational) |
| scl_in | input | 1 | SCL line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_in | input | 1 | SDA line level |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The bench sweeps the prescaler over several values and measures SCL high time and rise-to-rise spacing. It does this in the middle of a byte, which separates divider off-by-one errors from phase-order errors. A behavioural slave receives walking-one and walking-zero bytes. These patterns expose dropped, swapped or reversed bit positions that a random byte might hide. Reads return bytes built from an arithmetic pattern, with ACK on every byte except the last. This shows whether the ACK-in bit reaches the wire and whether the receive register fills in the right order. Three further cases are run: a wrong slave address (NACK), an intruder that pulls SDA low (arbitration), and soft reset or disable in the middle of a command. Together they separate the abort paths from normal completion.

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter int PW = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  reg_idx,
  input  logic        reg_we,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        scl_in,
  output logic        scl_oe,
  input  logic        sda_in,
  output logic        sda_oe
);

  localparam logic [2:0] IX_CFG  = 3'd0;
  localparam logic [2:0] IX_CTRL = 3'd1;
  localparam logic [2:0] IX_TX   = 3'd2;
  localparam logic [2:0] IX_RX   = 3'd3;
  localparam logic [2:0] IX_STAT = 3'd4;
  localparam logic [2:0] PH_LAST = 3'd4;
  localparam logic [3:0] ACK_SLOT = 4'd8;

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_BIT, ST_STOP} st_t;

  st_t           st;
  logic          en, srst;
  logic [PW-1:0] presc, div;
  logic          done;
  logic          c_start, c_stop, c_rd, c_wr, c_ack;
  logic [7:0]    tx, rx, sh;
  logic          arb, busy, ack_rx, smp;
  logic [2:0]    ph;
  logic [3:0]    bitn;
  logic [1:0]    scl_sy, sda_sy;
  logic          scl_p, sda_p;
  logic          scl_d, sda_d;
  logic          unused_bits;

  assign unused_bits = ^reg_wdata;

  wire run      = en & ~srst;
  wire wr_cfg   = reg_we && (reg_idx == IX_CFG);
  wire wr_ctrl  = reg_we && (reg_idx == IX_CTRL);
  wire wr_tx    = reg_we && (reg_idx == IX_TX);
  wire accept   = wr_ctrl && (|reg_wdata[7:4]) && run && (st == ST_IDLE);
  wire tick     = (st != ST_IDLE) && (div == presc);
  wire ph_end   = tick && (ph == PH_LAST);
  wire smp_pt   = tick && (ph == 3'd3);
  wire last_bit = (bitn == ACK_SLOT);

  wire arb_hit = run && smp_pt && (st == ST_BIT) && c_wr && !last_bit && sh[7] && !sda_sy[1];
  wire fin     = run && ph_end &&
                 ((st == ST_STOP) ||
                  (st == ST_BIT && last_bit && !c_stop) ||
                  (st == ST_START && !c_rd && !c_wr && !c_stop));

  wire bus_start = scl_sy[1] && scl_p && sda_p && !sda_sy[1];
  wire bus_stop  = scl_sy[1] && scl_p && !sda_p && sda_sy[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en    <= 1'b0;
      srst  <= 1'b0;
      presc <= '0;
      tx    <= '0;
    end else begin
      if (wr_cfg) begin
        en   <= reg_wdata[0];
        srst <= reg_wdata[1];
        if (!en) presc <= reg_wdata[16 +: PW];
      end
      if (wr_tx) tx <= reg_wdata[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      ph     <= '0;
      bitn   <= '0;
      div    <= '0;
      sh     <= '0;
      smp    <= 1'b1;
      rx     <= '0;
      ack_rx <= 1'b0;
      arb    <= 1'b0;
      {c_start, c_stop, c_rd, c_wr, c_ack} <= '0;
    end else if (!run) begin
      st   <= ST_IDLE;
      ph   <= '0;
      bitn <= '0;
      div  <= '0;
      {c_start, c_stop, c_rd, c_wr, c_ack} <= '0;
    end else if (arb_hit) begin
      st  <= ST_IDLE;
      arb <= 1'b1;
      {c_start, c_stop, c_rd, c_wr, c_ack} <= '0;
    end else if (accept) begin
      st      <= reg_wdata[7] ? ST_START : ((reg_wdata[5] | reg_wdata[4]) ? ST_BIT : ST_STOP);
      ph      <= '0;
      bitn    <= '0;
      div     <= '0;
      sh      <= tx;
      arb     <= 1'b0;
      c_ack   <= reg_wdata[3];
      c_wr    <= reg_wdata[4];
      c_rd    <= reg_wdata[5];
      c_stop  <= reg_wdata[6];
      c_start <= reg_wdata[7];
    end else if (st != ST_IDLE) begin
      div <= tick ? '0 : div + 1'b1;
      if (smp_pt) smp <= sda_sy[1];
      if (tick) ph <= (ph == PH_LAST) ? 3'd0 : ph + 3'd1;
      if (ph_end) begin
        case (st)
          ST_START: st <= (c_rd | c_wr) ? ST_BIT : (c_stop ? ST_STOP : ST_IDLE);
          ST_BIT: begin
            if (!last_bit) begin
              bitn <= bitn + 4'd1;
              sh   <= {sh[6:0], smp};
              if (bitn == 4'd7 && !c_wr) rx <= {sh[6:0], smp};
            end else begin
              if (c_wr) ack_rx <= smp;
              st <= c_stop ? ST_STOP : ST_IDLE;
            end
          end
          default: st <= ST_IDLE;
        endcase
        if (fin) {c_start, c_stop, c_rd, c_wr, c_ack} <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else if (fin || arb_hit) done <= 1'b1;
    else if (wr_ctrl && reg_wdata[0]) done <= 1'b0;
  end

  always_comb begin
    scl_d = scl_oe;
    sda_d = sda_oe;
    case (st)
      ST_START: begin
        scl_d = (ph == 3'd0) ? scl_oe : (ph == PH_LAST);
        sda_d = (ph >= 3'd3);
      end
      ST_BIT: begin
        scl_d = (ph < 3'd2) || (ph == PH_LAST);
        sda_d = c_wr ? (!last_bit && !sh[7]) : (last_bit && !c_ack);
      end
      ST_STOP: begin
        scl_d = (ph < 3'd2);
        sda_d = (ph < 3'd3);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
    end else if (!run || arb_hit) begin
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
    end else if (st != ST_IDLE) begin
      scl_oe <= scl_d;
      sda_oe <= sda_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
      busy   <= 1'b0;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      scl_p  <= scl_sy[1];
      sda_p  <= sda_sy[1];
      if (bus_start) busy <= 1'b1;
      else if (bus_stop) busy <= 1'b0;
    end
  end

  always_comb begin
    case (reg_idx)
      IX_CFG:  reg_rdata = (32'(presc) << 16) | {30'd0, srst, en};
      IX_CTRL: reg_rdata = {24'd0, c_start, c_stop, c_rd, c_wr, c_ack, 2'b00, done};
      IX_TX:   reg_rdata = {24'd0, tx};
      IX_RX:   reg_rdata = {24'd0, rx};
      IX_STAT: reg_rdata = {29'd0, ack_rx, busy, arb};
      default: reg_rdata = 32'd0;
    endcase
  end

  AST_PRESC_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en) |-> $stable(presc)); // R2

  AST_DONE_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (st == ST_IDLE)); // R7

  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && reg_wdata[0] && !fin && !arb_hit) |=> !done); // R7

  AST_ARB_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb) |-> (st == ST_IDLE && !scl_oe && !sda_oe)); // R9

  AST_HALT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (st == ST_IDLE && !scl_oe && !sda_oe)); // R10

  AST_SDA_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !scl_oe && !$past(scl_oe)) |->
      ($past(st) == ST_START || $past(st) == ST_STOP || $past(!run))); // R11

endmodule

// File: tb/i2c_byte_master_bench.sv
module i2c_byte_master_bench;

  localparam logic [6:0] SLV = 7'h2A;
  localparam logic [31:0] K_START = 32'h80, K_STOP = 32'h40, K_RD = 32'h20, K_WR = 32'h10, K_ACK = 32'h08;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] reg_idx = '0;
  logic reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic scl_oe, sda_oe;
  logic slv_low = 1'b0;
  logic intr_low = 1'b0;
  wire scl_w = !scl_oe;
  wire sda_w = !(sda_oe || slv_low || intr_low);

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit over = 0;

  always #4 clk = ~clk;

  i2c_byte_master u_i2c_byte_master (
    .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .scl_in(scl_w), .scl_oe(scl_oe), .sda_in(sda_w), .sda_oe(sda_oe));

  // behavioural slave
  int bcnt = 0, widx = 0, ridx = 0, nmack = 0, nstart = 0, nstop = 0;
  bit active = 0, addr_ph = 0, sel = 0, rdm = 0, pend_rd = 0, sending = 0;
  logic [7:0] sr = '0, txb = '0;
  logic [7:0] wmem [0:31];
  logic mack [0:15];

  function automatic logic [7:0] rpat(int k);
    return 8'(8'hC3 ^ (k * 29));
  endfunction

  always @(negedge sda_w) if (scl_w === 1'b1) begin
    nstart++; active = 1; bcnt = 0; addr_ph = 1; sel = 0; rdm = 0;
    pend_rd = 0; sending = 0; slv_low = 0; ridx = 0; widx = 0; nmack = 0;
  end
  always @(posedge sda_w) if (scl_w === 1'b1) begin
    nstop++; active = 0; sel = 0; sending = 0; pend_rd = 0; slv_low = 0;
  end
  always @(posedge scl_w) if (active) begin
    bcnt++;
    if (bcnt <= 8) sr = {sr[6:0], sda_w};
    else if (sending) begin
      mack[nmack] = sda_w; nmack++;
      if (sda_w) sending = 0;
    end
  end
  always @(negedge scl_w) if (active) begin
    if (bcnt == 8) begin
      if (addr_ph) begin
        addr_ph = 0; sel = (sr[7:1] == SLV); rdm = sr[0];
        slv_low = sel; pend_rd = sel && sr[0];
      end else if (sel && !rdm) begin
        wmem[widx] = sr; widx++; slv_low = 1;
      end else slv_low = 0;
    end else if (bcnt == 9) begin
      bcnt = 0; slv_low = 0;
      if (pend_rd) begin pend_rd = 0; sending = 1; end
      if (sending) begin txb = rpat(ridx); ridx++; slv_low = !txb[7]; end
    end else if (bcnt >= 1 && bcnt <= 7 && sending) begin
      slv_low = !txb[7 - bcnt];
    end
  end

  // SCL timing monitor
  int rise_gap = 0, last_period = 0, hi_cnt = 0, last_hi = 0;
  always @(posedge clk) begin
    rise_gap++;
    if (scl_w) hi_cnt++;
  end
  always @(posedge scl_w) begin last_period = rise_gap; rise_gap = 0; end
  always @(negedge scl_w) begin last_hi = hi_cnt; hi_cnt = 0; end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_idx = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_idx = a; #1; d = reg_rdata;
  endtask

  task automatic wait_done(input string req);
    logic [31:0] v;
    v = '0;
    for (int i = 0; i < 6000; i++) begin
      rreg(3'd1, v);
      if (v[0]) break;
    end
    chk({req, " R7 done/cmd bits"}, v, 32'h1);
    wreg(3'd1, 32'h1);
    rreg(3'd1, v);
    chk("R7 done cleared", v, 32'h0);
  endtask

  task automatic cmd(input logic [31:0] bits, input logic [7:0] b, input string req);
    wreg(3'd2, {24'd0, b});
    wreg(3'd1, bits);
    wait_done(req);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !over) begin
      over = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int s0, p0;
    idle(5);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rreg(3'(a), v);
      chk("R1 reset register", v, 32'h0);
    end
    chk("R1 line outputs released", {30'd0, scl_oe, sda_oe}, 32'h0);

    // R2 prescaler lock
    wreg(3'd0, 32'h0002_0001);
    rreg(3'd0, v); chk("R2 prescaler load", v, 32'h0002_0001);
    wreg(3'd0, 32'h0009_0001);
    rreg(3'd0, v); chk("R2 prescaler locked while enabled", v, 32'h0002_0001);

    // R10 commands ignored while disabled
    wreg(3'd0, 32'h0);
    wreg(3'd2, 32'h54);
    wreg(3'd1, K_START | K_WR);
    idle(60);
    rreg(3'd1, v); chk("R10 command ignored when disabled", v, 32'h0);
    chk("R10 lines idle when disabled", {30'd0, scl_oe, sda_oe}, 32'h0);

    for (int p = 1; p <= 3; p++) begin
      int nb;
      nb = (p == 1) ? 16 : 3;
      wreg(3'd0, 32'h0);
      wreg(3'd0, (32'(p) << 16) | 32'h1);
      s0 = nstart; p0 = nstop;
      cmd(K_START | K_WR, {SLV, 1'b0}, "R4 address write");
      rreg(3'd4, v); chk("R4 slave ack + R8 busy", v & 32'h6, 32'h2);
      for (int k = 0; k < nb; k++) begin
        logic [7:0] d;
        if (nb == 16) d = (k < 8) ? 8'(1 << k) : ~8'(1 << (k - 8));
        else d = 8'(p * 37 + k * 91);
        if (k == nb - 1) cmd(K_WR | K_STOP, d, "R6 last write");
        else begin
          wreg(3'd2, {24'd0, d});
          wreg(3'd1, K_WR);
          if (k == 0) begin
            rreg(3'd1, v); chk("R7 pending command bits", v, K_WR);
          end
          wait_done("R4 data write");
          chk("R3 SCL period", 32'(last_period), 32'(5 * (p + 1)));
          chk("R3 SCL high time", 32'(last_hi), 32'(2 * (p + 1)));
        end
      end
      idle(12);
      rreg(3'd4, v); chk("R8 busy cleared after stop", v, 32'h0);
      chk("R6 lines released", {30'd0, scl_oe, sda_oe}, 32'h0);
      chk("R11 one start per write", 32'(nstart - s0), 32'h1);
      chk("R11 one stop per write", 32'(nstop - p0), 32'h1);
      for (int k = 0; k < nb; k++) begin
        logic [7:0] d;
        if (nb == 16) d = (k < 8) ? 8'(1 << k) : ~8'(1 << (k - 8));
        else d = 8'(p * 37 + k * 91);
        chk("R4 byte at slave", {24'd0, wmem[k]}, {24'd0, d});
      end

      // read transaction
      cmd(K_START | K_WR, {SLV, 1'b1}, "R4 address read");
      for (int k = 0; k < 3; k++) begin
        if (k == 2) cmd(K_RD | K_ACK | K_STOP, 8'h00, "R5 last read");
        else cmd(K_RD, 8'h00, "R5 read");
        rreg(3'd3, v); chk("R5 received byte", v, {24'd0, rpat(k)});
      end
      idle(12);
      chk("R5 master ack count", 32'(nmack), 32'd3);
      chk("R5 ack on byte 0", {31'd0, mack[0]}, 32'h0);
      chk("R5 ack on byte 1", {31'd0, mack[1]}, 32'h0);
      chk("R5 nack on final byte", {31'd0, mack[2]}, 32'h1);
      chk("R6 lines released after read", {30'd0, scl_oe, sda_oe}, 32'h0);
    end

    // R4 wrong address gives NACK
    cmd(K_START | K_WR, 8'h22, "R4 wrong address");
    rreg(3'd4, v); chk("R4 nack level stored", v & 32'h4, 32'h4);
    cmd(K_STOP, 8'h00, "R6 stop only");
    idle(12);
    rreg(3'd4, v); chk("R8 busy clear", v & 32'h2, 32'h0);

    // R9 arbitration
    wreg(3'd2, 32'hFF);
    wreg(3'd1, K_START | K_WR);
    @(posedge scl_w); #1 intr_low = 1'b1;
    wait_done("R9 abort");
    rreg(3'd4, v); chk("R9 arbitration flag", v & 32'h1, 32'h1);
    chk("R9 lines released", {30'd0, scl_oe, sda_oe}, 32'h0);
    intr_low = 1'b0;
    idle(12);
    cmd(K_START | K_WR, {SLV, 1'b0}, "R9 recover");
    rreg(3'd4, v); chk("R9 flag cleared by new command", v & 32'h5, 32'h0);
    cmd(K_WR | K_STOP, 8'h3E, "R9 recover stop");
    chk("R9 byte after recovery", {24'd0, wmem[0]}, 32'h3E);

    // R10 soft reset mid command
    wreg(3'd2, {24'd0, SLV, 1'b0});
    wreg(3'd1, K_START | K_WR);
    @(posedge scl_w);
    wreg(3'd0, 32'h0001_0003);
    idle(2);
    chk("R10 soft reset releases lines", {30'd0, scl_oe, sda_oe}, 32'h0);
    rreg(3'd1, v); chk("R10 soft reset aborts without done", v, 32'h0);
    wreg(3'd0, 32'h0001_0001);
    idle(12);
    cmd(K_START | K_WR, {SLV, 1'b0}, "R10 after soft reset");
    cmd(K_WR | K_STOP, 8'h99, "R10 after soft reset");
    chk("R10 transfer after soft reset", {24'd0, wmem[0]}, 32'h99);

    if (!over) begin
      over = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule